// File: doc/BRIEF.md
# Compare Flags and Predication Unit

This block performs a 32-bit add, subtract or compare, derives the negative, zero, carry and overflow flags from it and keeps them in a status word. In the same cycle it evaluates the 4-bit condition field of the instruction being issued against the flags held before the clock edge. The resulting pass decision gates both the result write-back and the flag update, so branches and ordinary data operations are predicated in the same way.

The status word also holds a sticky saturation bit, two interrupt-mask bits, a state bit and a five-bit mode field. These are plain fields that a whole-word write port can load. A compare computes the difference and updates the flags but never requests a result write.

Top module: `cfp_unit`

## Requirements
- R1: After synchronous active-low reset the status word reads 0x000000D3: flags, Q and T are clear, I (bit 7) and F (bit 6) are set, and the mode (bits 4..0) is 10011.
- R2: With op_sel 00 (add), result is opa+opb modulo 2^32. The flags written are N = result bit 31, Z = result all zero, C = carry out of bit 31, and V = both operands of equal sign with the result sign different.
- R3: With op_sel 01 (subtract) or 1x (compare), result is opa-opb. C is set when opa >= opb unsigned, meaning no borrow. V is set when the operand signs differ and the result sign differs from opa's.
- R4: A compare (op_sel bit 1 set) never raises result_we, yet it updates the flags like a subtract.
- R5: cond_pass for the simple codes: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V.
- R6: cond_pass for the compound codes: 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V).
- R7: Code 1110 always passes and code 1111 never passes, whatever the flags.
- R8: When the condition fails, result_we stays low and the flags keep their value across the edge.
- R9: When set_flags is low, the flags keep their value even if the issued operation passes.
- R10: cond_pass uses the flags registered before the current edge. An update written at one edge is seen by the instruction issued in the next cycle.
- R11: sr_we loads bits 31..27 and 7..0 from sr_wdata, and bits 26..8 always read zero. If a flag update happens in the same cycle, the arithmetic result sets bits 31..28 and the write sets all other fields.
- R12: With issue_vld low, result_we is low and no flag update takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| op_sel | input | 2 | 00 add, 01 subtract, 1x compare |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (register or immediate) |
| set_flags | input | 1 | Request to update the flags |
| cond | input | 4 | Condition field of the issued instruction |
| sr_we | input | 1 | Status word write strobe |
| sr_wdata | input | 32 | Status word write data |
| result | output | 32 | Arithmetic result |
| result_we | output | 1 | Result may be written back |
| cond_pass | output | 1 | Condition holds on the current flags |
| status | output | 32 | Registered status word |

## Verification
The arithmetic is driven with operand pairs chosen to separate the flags: a plain sum, signed overflow into the sign bit, unsigned wrap to zero, and subtractions with and without borrow, including the most-negative operand. The condition evaluator is swept over all sixteen codes for each of the sixteen flag combinations, which separates every code from its complement and from its neighbours. Further targeted sequences exercise a failed predicate, set_flags held low, an idle issue slot, back-to-back dependent instructions and a status write that collides with a flag update.

// File: rtl/cfp_pkg.sv
// Package: shared encodings and status word layout of the compare flags unit.
// Assumes a 32-bit status word; field positions are fixed by the layout below.
package cfp_pkg;
    localparam int SR_W    = 32;
    localparam int SR_N    = 31;
    localparam int SR_Z    = 30;
    localparam int SR_C    = 29;
    localparam int SR_V    = 28;
    localparam int SR_Q    = 27;
    localparam int SR_I    = 7;
    localparam int SR_F    = 6;
    localparam int SR_T    = 5;
    localparam int MODE_W  = 5;

    // Flag bundle carried between the arithmetic, evaluator and register.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    // Operation select; bit 1 marks a compare.
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CMP = 2'b10,
        OP_CMX = 2'b11
    } op_e;
endpackage

// File: rtl/cfp_arith.sv
// Module: adder/subtractor producing a result and its four flags.
// Assumes subtraction is formed as a + ~b + 1; compare uses the subtract path.
module cfp_arith
    import cfp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output flags_t            flg
);
    localparam int MSB = DATA_W - 1;

    logic              is_sub;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum;

    // Select operand inversion and carry-in for subtract or compare.
    always_comb begin
        is_sub = (op_sel != OP_ADD);
        b_eff  = is_sub ? ~opb : opb;
        sum    = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
        res    = sum[MSB:0];
    end

    // Derive the flags from the sum and the operand signs.
    always_comb begin
        flg.n = res[MSB];
        flg.z = (res == '0);
        flg.c = sum[DATA_W];
        if (is_sub)
            flg.v = (opa[MSB] != opb[MSB]) && (res[MSB] != opa[MSB]);
        else
            flg.v = (opa[MSB] == opb[MSB]) && (res[MSB] != opa[MSB]);
    end
endmodule

// File: rtl/cfp_cond_eval.sv
// Module: evaluates a 4-bit condition code against the registered flags.
// Assumes codes 0..13 come in pairs whose low bit inverts the test,
// 1110 always passes and 1111 never passes.
module cfp_cond_eval
    import cfp_pkg::*;
#(
    parameter int COND_W = 4
) (
    input  logic [COND_W-1:0] cond,
    input  flags_t            flg,
    output logic              pass
);
    logic base;

    // Evaluate the even member of each condition pair.
    always_comb begin
        unique case (cond[COND_W-1:1])
            3'd0:    base = flg.z;
            3'd1:    base = flg.c;
            3'd2:    base = flg.n;
            3'd3:    base = flg.v;
            3'd4:    base = flg.c & ~flg.z;
            3'd5:    base = (flg.n == flg.v);
            3'd6:    base = ~flg.z & (flg.n == flg.v);
            default: base = 1'b1;
        endcase
    end

    // Apply the pair inversion and the always/never codes.
    always_comb begin
        if (cond[COND_W-1:1] == 3'd7)
            pass = ~cond[0];
        else
            pass = base ^ cond[0];
    end
endmodule

// File: rtl/cfp_status_reg.sv
// Module: status word register holding flags, sticky Q, masks, state and mode.
// Assumes a whole-word write; a flag update in the same cycle wins for N,Z,C,V.
module cfp_status_reg
    import cfp_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011,
    parameter logic              RESET_I    = 1'b1,
    parameter logic              RESET_F    = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flg_upd,
    input  flags_t          flg_new,
    input  logic            wr_en,
    input  logic [SR_W-1:0] wr_data,
    output flags_t          flg_q,
    output logic [SR_W-1:0] word
);
    logic              q_bit, i_bit, f_bit, t_bit;
    logic [MODE_W-1:0] mode;

    // Flag register: arithmetic update has priority over the word write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flg_q <= '0;
        else if (flg_upd)
            flg_q <= flg_new;
        else if (wr_en)
            flg_q <= wr_data[SR_N:SR_V];
    end

    // Control fields loaded only by the word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_bit <= 1'b0;
            i_bit <= RESET_I;
            f_bit <= RESET_F;
            t_bit <= 1'b0;
            mode  <= RESET_MODE;
        end else if (wr_en) begin
            q_bit <= wr_data[SR_Q];
            i_bit <= wr_data[SR_I];
            f_bit <= wr_data[SR_F];
            t_bit <= wr_data[SR_T];
            mode  <= wr_data[MODE_W-1:0];
        end
    end

    // Assemble the visible word; unused bits read zero.
    always_comb begin
        word                = '0;
        word[SR_N:SR_V]     = flg_q;
        word[SR_Q]          = q_bit;
        word[SR_I]          = i_bit;
        word[SR_F]          = f_bit;
        word[SR_T]          = t_bit;
        word[MODE_W-1:0]    = mode;
    end
endmodule

// File: rtl/cfp_unit.sv
// Module: top of the compare flags and predication unit.
// Assumes one instruction per cycle; result and cond_pass are combinational,
// flags and control fields are registered.
module cfp_unit
    import cfp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              set_flags,
    input  logic [COND_W-1:0] cond,
    input  logic              sr_we,
    input  logic [SR_W-1:0]   sr_wdata,
    output logic [DATA_W-1:0] result,
    output logic              result_we,
    output logic              cond_pass,
    output logic [SR_W-1:0]   status
);
    flags_t alu_flg;
    flags_t cur_flg;
    logic   do_upd;

    cfp_arith #(.DATA_W(DATA_W)) u_arith (
        .op_sel (op_sel),
        .opa    (opa),
        .opb    (opb),
        .res    (result),
        .flg    (alu_flg)
    );

    cfp_cond_eval #(.COND_W(COND_W)) u_cond (
        .cond   (cond),
        .flg    (cur_flg),
        .pass   (cond_pass)
    );

    // Gate write-back and flag update with the predicate.
    always_comb begin
        result_we = issue_vld & cond_pass & ~op_sel[1];
        do_upd    = issue_vld & cond_pass & set_flags;
    end

    cfp_status_reg u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .flg_upd (do_upd),
        .flg_new (alu_flg),
        .wr_en   (sr_we),
        .wr_data (sr_wdata),
        .flg_q   (cur_flg),
        .word    (status)
    );
endmodule

// File: rtl/cfp_unit_chk.sv
// Module: property checker for cfp_unit, attached through bind.
module cfp_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue_vld,
    input logic [1:0]  op_sel,
    input logic [31:0] opa,
    input logic [31:0] opb,
    input logic        set_flags,
    input logic [3:0]  cond,
    input logic        sr_we,
    input logic [31:0] sr_wdata,
    input logic [31:0] result,
    input logic        result_we,
    input logic        cond_pass,
    input logic [31:0] status
);
    // R7: never code.
    a_r7_never_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'hF) |-> !cond_pass);
    // R7: always code.
    a_r7_always_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == 4'hE) |-> cond_pass);
    // R4: compare never writes back.
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && op_sel[1]) |-> !result_we);
    // R12: idle slot writes nothing.
    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |-> !result_we);
    // R8: failed predicate writes nothing.
    a_r8_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass |-> !result_we);
    // R9: flags hold without an update or a write.
    a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(issue_vld && set_flags && cond_pass) && !sr_we) |=> $stable(status[31:28]));
    // R2: Z after an update reflects the previous result.
    a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && set_flags && cond_pass) |=> (status[30] == ($past(result) == 32'd0)));
    // R11: unused bits read zero.
    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[26:8] == 19'd0);
endmodule

bind cfp_unit cfp_unit_chk u_chk (.*);

// File: tb/tb_cfp_unit.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module tb_cfp_unit;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] opa = '0, opb = '0;
    logic        set_flags = 1'b0;
    logic [3:0]  cond = 4'hE;
    logic        sr_we = 1'b0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] result;
    logic        result_we, cond_pass;
    logic [31:0] status;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] res;
        logic        chk_res;
        logic        we;
        logic        pass;
        logic [31:0] st;
        string       tag;
    } item_t;

    item_t sb[$];
    logic [31:0] m_st = 32'h000000D3;

    cfp_unit dut (.*);

    always #(CLK_P/2) clk = ~clk;

    function automatic logic model_pass(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected outputs.
    task automatic issue(input logic vld, input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sf, input logic [3:0] c, input logic we, input logic [31:0] wd,
                         input string tag);
        item_t it;
        logic [31:0] r;
        logic cy, v, p;
        longint sa, sb2, sr;
        @(negedge clk);
        issue_vld = vld; op_sel = op; opa = a; opb = b;
        set_flags = sf; cond = c; sr_we = we; sr_wdata = wd;
        sa = longint'($signed(a));
        sb2 = longint'($signed(b));
        if (op == 2'b00) begin
            r = a + b;
            cy = ({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF;
            sr = sa + sb2;
        end else begin
            r = a - b;
            cy = (a >= b);
            sr = sa - sb2;
        end
        v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
        p = model_pass(c, m_st[31:28]);
        it.res = r;
        it.chk_res = vld;
        it.we = vld && p && !op[1];
        it.pass = p;
        it.st = m_st;
        it.tag = tag;
        sb.push_back(it);
        if (we) m_st = wd & 32'hF80000FF;
        if (vld && sf && p) m_st[31:28] = {r[31], r == 32'd0, cy, v};
    endtask

    task automatic idle(input string tag);
        issue(1'b0, 2'b00, 32'd0, 32'd0, 1'b0, 4'hE, 1'b0, 32'd0, tag);
    endtask

    task automatic wr_sr(input logic [31:0] wd, input string tag);
        issue(1'b0, 2'b00, 32'd0, 32'd0, 1'b0, 4'hE, 1'b1, wd, tag);
    endtask

    // Monitor: compare the outputs a quarter period after each falling edge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            if (it.chk_res) chk(it.tag, "result", result, it.res);
            chk(it.tag, "result_we", {31'd0, result_we}, {31'd0, it.we});
            chk(it.tag, "cond_pass", {31'd0, cond_pass}, {31'd0, it.pass});
            chk(it.tag, "status", status, it.st);
        end
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset");                                                  // R1
        idle("R12 idle");                                                  // R12
        issue(1, 2'b00, 32'd5, 32'd7, 1, 4'hE, 0, 0, "R2 add small");       // R2
        issue(1, 2'b00, 32'h7FFFFFFF, 32'd1, 1, 4'hE, 0, 0, "R2 add ovf");
        issue(1, 2'b00, 32'hFFFFFFFF, 32'd1, 1, 4'hE, 0, 0, "R2 add wrap");
        issue(1, 2'b01, 32'd5, 32'd3, 1, 4'hE, 0, 0, "R3 sub noborrow");   // R3
        issue(1, 2'b01, 32'd3, 32'd5, 1, 4'hE, 0, 0, "R3 sub borrow");
        issue(1, 2'b01, 32'h80000000, 32'd1, 1, 4'hE, 0, 0, "R3 sub ovf");
        issue(1, 2'b10, 32'd7, 32'd7, 1, 4'hE, 0, 0, "R4 cmp equal");      // R4
        issue(1, 2'b11, 32'd1, 32'd9, 1, 4'hE, 0, 0, "R4 cmp less");
        idle("R4 cmp flags");
        // R5 R6 R7: sweep every code over every flag combination.
        for (int f = 0; f < 16; f++) begin
            wr_sr({f[3:0], 28'h00000D3}, "R11 flag load");
            for (int c = 0; c < 16; c++)
                issue(1, 2'b00, 32'd1, 32'd2, 0, c[3:0], 0, 0,
                      (c < 8) ? "R5 simple" : (c < 14) ? "R6 compound" : "R7 always/never");
        end
        // R8: failing predicate has no effect.
        wr_sr(32'h400000D3, "R8 set Z");
        issue(1, 2'b00, 32'd1, 32'd1, 1, 4'h1, 0, 0, "R8 fail");
        idle("R8 after");
        // R9: no set_flags means no flag change.
        issue(1, 2'b01, 32'd4, 32'd4, 0, 4'hE, 0, 0, "R9 noflags");
        idle("R9 after");
        // R10: old flags decide, new flags seen next cycle.
        issue(1, 2'b00, 32'd2, 32'd3, 1, 4'h0, 0, 0, "R10 uses old Z");
        issue(1, 2'b10, 32'd1, 32'd2, 1, 4'h1, 0, 0, "R10 next sees NE");
        issue(1, 2'b00, 32'd9, 32'd1, 0, 4'h4, 0, 0, "R10 MI after cmp");
        // R11: write masking and collision.
        wr_sr(32'hFFFFFFFF, "R11 write all");
        idle("R11 masked");
        issue(1, 2'b00, 32'h7FFFFFFF, 32'd1, 1, 4'hE, 1, 32'h00000000, "R11 collide");
        idle("R11 after collide");
        // R12: idle slot with set_flags requested.
        issue(0, 2'b00, 32'd0, 32'd0, 1, 4'hE, 0, 0, "R12 idle sf");
        idle("R12 after");
        idle("end");
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule